// File: doc/BRIEF.md
# DMA Channel Address and Length Sequencer

This block holds the register state of one DMA channel and performs its transfer bookkeeping. Software sets it up through a simple register bus. It writes two 24-bit address counters, each with a reload register. It writes a 16-bit block length counter with its own reload register. It writes a 16-bit control word. A status register reports whether the next block has been armed.

The data mover that performs the actual reads and writes pulses `xfer_done` once for each completed transfer cycle. On that pulse the channel does three things:

- It steps the address counters.
- It decrements the length counter.
- It handles the end of a block.

The end of a block either chains to the armed next block or stops the channel.

The channel presents the current source and destination addresses and the transfer size to the data mover. It also pulses `blk_done` at the end of every block. It drives `clk_req` only while it is running, so that the DMA clock can be gated when every channel is idle.

Top module: `dmach_seq`

## Requirements
- R1: After reset the control word, the status flag, all counters and all reload registers are zero, and `clk_req`, `blk_done` and `reg_rdata` are 0.
- R2: The register map is as follows:
  - index 0: control
  - index 1: status (bit0 = armed flag)
  - index 2: A counter
  - index 3: A reload
  - index 4: B counter
  - index 5: B reload
  - index 6: length counter
  - index 7: length reload
  
  `reg_rdata` shows the register selected by `reg_addr` one cycle later. Address registers keep only bits 23:0, and bits 31:24 always read as zero.
- R3: The control bits are as follows:
  - bit0: run
  - bit3: wide
  - bit4: indirect
  - bit5: dir
  - bit9: A step enable
  - bits 11:10: A step mode
  - bit12: B step enable
  - bits 14:13: B step mode
  
  Bits 1, 2, 6, 7 and 8 are stored and read back. Bit15 always reads 0.
- R4: A control write with bit0=1 is a start, even when the channel is already running. A start loads the A counter and the length counter from their reload registers. It loads the B counter only when the written indirect bit is 1. It clears the armed flag.
- R5: On `xfer_done` while running, each address counter whose step enable bit is 1 changes at the next edge according to its mode:
  - 00 adds the transfer size.
  - 01 subtracts the transfer size.
  - 10 and 11 leave the address unchanged.
  
  Addresses wrap modulo 2^24.
- R6: `xfer_bytes` is 2 when the wide bit is 1, and 1 otherwise.
- R7: With dir=1, `src_addr` is the A counter and `dst_addr` is the B counter. With dir=0 they are swapped.
- R8: With the indirect bit at 0 (flyby), transfers and starts leave the B counter unchanged.
- R9: The length counter decreases by 1 on every accepted transfer. Writing 0 to the length counter or to the length reload stores 0xFFFF, so a zero length means 65535 transfers.
- R10: Writing the length reload register sets the armed flag.
- R11: A transfer accepted while the length counter is 1 ends the block, and `blk_done` is 1 for the next cycle. If the block ends with the armed flag set, the channel reloads the A counter, the length counter and, when indirect, the B counter. It then clears the armed flag and keeps running. If the flag is clear, the run bit clears and the length counter reads 0.
- R12: `clk_req` equals the run bit. `xfer_done` while not running changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| xfer_done | input | 1 | One completed transfer cycle |
| src_addr | output | 24 | Current source address |
| dst_addr | output | 24 | Current destination address |
| xfer_bytes | output | 2 | Transfer cycle size in bytes (1 or 2) |
| blk_done | output | 1 | One-cycle pulse at block end |
| clk_req | output | 1 | Clock enable request while running |

## Verification
The bench drives a block down to its last transfer twice. The first time the channel is unarmed, and a design that loses the terminal count would keep running or never pulse `blk_done`. The second time it is armed, and a design that fails to chain would stop or keep stale addresses.

The bench restarts a running channel by rewriting the run bit. A design that only reacts to a rising run bit would continue from the old counters.

The bench also covers three register corner cases:
- A zero length must read back as 0xFFFF, or a block would finish after 65536 transfers or none.
- Flyby mode must leave the B counter frozen.
- The upper address byte must read zero.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam int ADDR_W = 24;
  localparam int LEN_W  = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 3;

  // register indices; software decodes these
  localparam logic [IDX_W-1:0] RI_CTRL = 3'd0;
  localparam logic [IDX_W-1:0] RI_STAT = 3'd1;
  localparam logic [IDX_W-1:0] RI_ACNT = 3'd2;
  localparam logic [IDX_W-1:0] RI_ARLD = 3'd3;
  localparam logic [IDX_W-1:0] RI_BCNT = 3'd4;
  localparam logic [IDX_W-1:0] RI_BRLD = 3'd5;
  localparam logic [IDX_W-1:0] RI_LCNT = 3'd6;
  localparam logic [IDX_W-1:0] RI_LRLD = 3'd7;

  // step modes
  localparam logic [1:0] STEP_ADD = 2'b00;
  localparam logic [1:0] STEP_SUB = 2'b01;

  // control word, bit 15 down to bit 0
  typedef struct packed {
    logic       rsvd;
    logic [1:0] b_mode;
    logic       b_en;
    logic [1:0] a_mode;
    logic       a_en;
    logic       sw_req;
    logic       bus_pol;
    logic       one_txn;
    logic       dir;
    logic       indirect;
    logic       wide;
    logic       ovr_ie;
    logic       tc_ie;
    logic       run;
  } ctrl_t;

endpackage

// File: rtl/dmach_addr_ctr.sv
module dmach_addr_ctr #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_cnt,
  input  logic              wr_rld,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              load,
  input  logic              step,
  input  logic [1:0]        mode,
  input  logic [1:0]        size,
  output logic [ADDR_W-1:0] cnt,
  output logic [ADDR_W-1:0] rld
);
  import dmach_pkg::*;

  logic [ADDR_W-1:0] stride;
  logic [ADDR_W-1:0] stepped;

  assign stride = ADDR_W'(size);

  always_comb begin
    unique case (mode)
      STEP_ADD: stepped = cnt + stride;
      STEP_SUB: stepped = cnt - stride;
      default:  stepped = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rld <= '0;
    end else begin
      if (wr_rld) rld <= wdata;
      if (wr_cnt)      cnt <= wdata;
      else if (load)   cnt <= rld;
      else if (step)   cnt <= stepped;
    end
  end

endmodule

// File: rtl/dmach_len_ctr.sv
module dmach_len_ctr #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_cnt,
  input  logic             wr_rld,
  input  logic [LEN_W-1:0] wdata,
  input  logic             load,
  input  logic             dec,
  output logic [LEN_W-1:0] cnt,
  output logic [LEN_W-1:0] rld,
  output logic             last
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  // a zero length means the largest count
  function automatic logic [LEN_W-1:0] fix_len(input logic [LEN_W-1:0] v);
    return (v == '0) ? '1 : v;
  endfunction

  assign last = (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      rld <= '0;
    end else begin
      if (wr_rld) rld <= fix_len(wdata);
      if (wr_cnt)      cnt <= fix_len(wdata);
      else if (load)   cnt <= rld;
      else if (dec)    cnt <= cnt - ONE;
    end
  end

endmodule

// File: rtl/dmach_seq.sv
module dmach_seq
  import dmach_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic [1:0]        xfer_bytes,
  output logic              blk_done,
  output logic              clk_req
);

  localparam int NCTR = 2;

  ctrl_t ctrl, ctrl_nxt;
  logic  vld;

  logic ctrl_wr, start, step, last_evt, chain, len_wr, ind_eff;
  logic len_last;
  logic [LEN_W-1:0] len_cnt, len_rld;

  logic [ADDR_W-1:0] a_cnt [NCTR];
  logic [ADDR_W-1:0] a_rld [NCTR];
  logic [NCTR-1:0]   c_wr, r_wr, c_ld, c_st;
  logic [1:0]        c_mode [NCTR];
  logic [ADDR_W-1:0] b_cnt;

  assign ctrl_wr  = reg_wr && (reg_addr == RI_CTRL);
  assign start    = ctrl_wr && reg_wdata[0];
  assign ind_eff  = ctrl_wr ? reg_wdata[4] : ctrl.indirect;
  assign step     = xfer_done && ctrl.run && !start;
  assign last_evt = step && len_last;
  assign chain    = last_evt && vld;
  assign len_wr   = reg_wr && ((reg_addr == RI_LCNT) || (reg_addr == RI_LRLD));
  assign xfer_bytes = ctrl.wide ? 2'd2 : 2'd1;

  assign c_wr   = {reg_wr && (reg_addr == RI_BCNT), reg_wr && (reg_addr == RI_ACNT)};
  assign r_wr   = {reg_wr && (reg_addr == RI_BRLD), reg_wr && (reg_addr == RI_ARLD)};
  assign c_ld   = {(start || chain) && ind_eff, start || chain};
  assign c_st   = {step && ctrl.b_en && ctrl.indirect, step && ctrl.a_en};
  assign c_mode[0] = ctrl.a_mode;
  assign c_mode[1] = ctrl.b_mode;

  for (genvar g = 0; g < NCTR; g++) begin : g_actr
    dmach_addr_ctr #(.ADDR_W(ADDR_W)) u_actr (
      .clk    (clk),
      .rst    (rst),
      .wr_cnt (c_wr[g]),
      .wr_rld (r_wr[g]),
      .wdata  (reg_wdata[ADDR_W-1:0]),
      .load   (c_ld[g]),
      .step   (c_st[g]),
      .mode   (c_mode[g]),
      .size   (xfer_bytes),
      .cnt    (a_cnt[g]),
      .rld    (a_rld[g])
    );
  end

  assign b_cnt = a_cnt[1];

  dmach_len_ctr #(.LEN_W(LEN_W)) u_len (
    .clk    (clk),
    .rst    (rst),
    .wr_cnt (reg_wr && (reg_addr == RI_LCNT)),
    .wr_rld (reg_wr && (reg_addr == RI_LRLD)),
    .wdata  (reg_wdata[LEN_W-1:0]),
    .load   (start || chain),
    .dec    (step && !chain),
    .cnt    (len_cnt),
    .rld    (len_rld),
    .last   (len_last)
  );

  assign src_addr = ctrl.dir ? a_cnt[0] : a_cnt[1];
  assign dst_addr = ctrl.dir ? a_cnt[1] : a_cnt[0];

  always_comb begin
    ctrl_nxt = ctrl;
    if (ctrl_wr) begin
      ctrl_nxt = ctrl_t'({1'b0, reg_wdata[14:0]});
    end else if (last_evt && !vld) begin
      ctrl_nxt.run = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      vld      <= 1'b0;
      blk_done <= 1'b0;
      clk_req  <= 1'b0;
    end else begin
      ctrl     <= ctrl_nxt;
      blk_done <= last_evt;
      clk_req  <= ctrl_nxt.run;
      if (reg_wr && (reg_addr == RI_LRLD)) vld <= 1'b1;
      else if (start || chain)             vld <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      unique case (reg_addr)
        RI_CTRL: reg_rdata <= DATA_W'(ctrl);
        RI_STAT: reg_rdata <= DATA_W'(vld);
        RI_ACNT: reg_rdata <= DATA_W'(a_cnt[0]);
        RI_ARLD: reg_rdata <= DATA_W'(a_rld[0]);
        RI_BCNT: reg_rdata <= DATA_W'(a_cnt[1]);
        RI_BRLD: reg_rdata <= DATA_W'(a_rld[1]);
        RI_LCNT: reg_rdata <= DATA_W'(len_cnt);
        default: reg_rdata <= DATA_W'(len_rld);
      endcase
    end
  end

endmodule

// File: rtl/dmach_seq_chk.sv
module dmach_seq_chk
  import dmach_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [IDX_W-1:0]  reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              clk_req,
  input logic              blk_done,
  input logic [ADDR_W-1:0] src_addr,
  input logic [ADDR_W-1:0] b_cnt,
  input logic [LEN_W-1:0]  len_cnt,
  input logic              step,
  input logic              last_evt,
  input logic              vld,
  input logic              ctrl_wr,
  input logic              len_wr,
  input logic              indirect
);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    reg_rdata[DATA_W-1:ADDR_W] == '0);

  p_flyby_b_r8: assert property (@(posedge clk) disable iff (rst)
    (!indirect && !ctrl_wr && !(reg_wr && reg_addr == RI_BCNT)) |=> $stable(b_cnt));

  p_len_dec_r9: assert property (@(posedge clk) disable iff (rst)
    (step && !last_evt && !len_wr) |=> (len_cnt == $past(len_cnt) - LEN_W'(1)));

  p_arm_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == RI_LRLD) |=> vld);

  p_blk_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    last_evt |=> blk_done);

  p_stop_r11: assert property (@(posedge clk) disable iff (rst)
    (last_evt && !vld && !ctrl_wr) |=> !clk_req);

  p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!clk_req && !reg_wr) |=> $stable(src_addr));

endmodule

bind dmach_seq dmach_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .clk_req   (clk_req),
  .blk_done  (blk_done),
  .src_addr  (src_addr),
  .b_cnt     (b_cnt),
  .len_cnt   (len_cnt),
  .step      (step),
  .last_evt  (last_evt),
  .vld       (vld),
  .ctrl_wr   (ctrl_wr),
  .len_wr    (len_wr),
  .indirect  (ctrl.indirect)
);

// File: tb/dmach_seq_bench.sv
module dmach_seq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_done = 1'b0;
  logic [23:0] src_addr, dst_addr;
  logic [1:0]  xfer_bytes;
  logic        blk_done, clk_req;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  dmach_seq u_dmach_seq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .src_addr(src_addr), .dst_addr(dst_addr), .xfer_bytes(xfer_bytes),
    .blk_done(blk_done), .clk_req(clk_req)
  );

  localparam logic [31:0] CTL_MAIN = 32'h0000_3239; // run wide ind dir A+ B-
  localparam logic [31:0] CTL_FLY  = 32'h0000_1201; // run, flyby, dir0, A+ B+
  localparam logic [31:0] CTL_HOLD = 32'h0000_0A01; // run, flyby, A hold

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic xfer();
    @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 clk_req", 32'(clk_req), 0);
    chk("R1 blk_done", 32'(blk_done), 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 status", d, 0);
    rd(3'd6, d); chk("R1 length", d, 0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    wr(3'd3, 32'hFF12_3456);
    rd(3'd3, d); chk("R2 upper byte zero", d, 32'h0012_3456);
    wr(3'd0, 32'hFFFF_FFFE);
    rd(3'd0, d); chk("R3 control fields", d, 32'h0000_7FFE);
    chk("R12 no clk_req when stopped", 32'(clk_req), 0);
  endtask

  task automatic t_start_step();
    logic [31:0] d;
    wr(3'd3, 32'h100);
    wr(3'd5, 32'h2000);
    wr(3'd7, 32'd4);
    rd(3'd1, d); chk("R10 armed", d, 1);
    wr(3'd0, CTL_MAIN);
    chk("R4 src load", 32'(src_addr), 32'h100);
    chk("R7 dst is B", 32'(dst_addr), 32'h2000);
    chk("R6 wide", 32'(xfer_bytes), 2);
    chk("R12 clk_req", 32'(clk_req), 1);
    rd(3'd1, d); chk("R4 start clears armed", d, 0);
    xfer();
    chk("R5 add", 32'(src_addr), 32'h102);
    chk("R5 sub", 32'(dst_addr), 32'h1FFE);
    rd(3'd6, d); chk("R9 decrement", d, 3);
    wr(3'd0, CTL_MAIN);
    chk("R4 restart while running", 32'(src_addr), 32'h100);
    rd(3'd6, d); chk("R4 restart length", d, 4);
  endtask

  task automatic t_stop();
    logic [31:0] d;
    wr(3'd7, 32'd2);
    wr(3'd0, CTL_MAIN);
    xfer();
    chk("R11 no early done", 32'(blk_done), 0);
    xfer();
    chk("R11 done pulse", 32'(blk_done), 1);
    chk("R11 stop", 32'(clk_req), 0);
    chk("R5 final step", 32'(src_addr), 32'h104);
    rd(3'd6, d); chk("R11 length zero", d, 0);
    xfer();
    chk("R12 ignored when idle", 32'(src_addr), 32'h104);
    chk("R11 pulse one cycle", 32'(blk_done), 0);
  endtask

  task automatic t_chain();
    logic [31:0] d;
    wr(3'd0, CTL_MAIN);
    wr(3'd3, 32'h500);
    wr(3'd7, 32'd3);
    xfer();
    xfer();
    chk("R11 chain done", 32'(blk_done), 1);
    chk("R11 chain keeps running", 32'(clk_req), 1);
    chk("R11 chain reload A", 32'(src_addr), 32'h500);
    chk("R11 chain reload B", 32'(dst_addr), 32'h2000);
    rd(3'd6, d); chk("R11 chain length", d, 3);
    rd(3'd1, d); chk("R11 chain clears armed", d, 0);
  endtask

  task automatic t_flyby();
    wr(3'd4, 32'h777);
    wr(3'd0, CTL_FLY);
    chk("R8 B not loaded", 32'(src_addr), 32'h777);
    chk("R7 dst is A", 32'(dst_addr), 32'h500);
    chk("R6 narrow", 32'(xfer_bytes), 1);
    xfer();
    chk("R5 byte step", 32'(dst_addr), 32'h501);
    chk("R8 B frozen", 32'(src_addr), 32'h777);
  endtask

  task automatic t_zero_len();
    logic [31:0] d;
    wr(3'd7, 32'd0);
    rd(3'd7, d); chk("R9 zero reload", d, 32'hFFFF);
    wr(3'd0, CTL_HOLD);
    xfer();
    chk("R5 hold mode", 32'(dst_addr), 32'h500);
    rd(3'd6, d); chk("R9 from max", d, 32'hFFFE);
    wr(3'd6, 32'd0);
    rd(3'd6, d); chk("R9 zero counter", d, 32'hFFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_start_step();
    t_stop();
    t_chain();
    t_flyby();
    t_zero_len();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule